// File: doc/BRIEF.md
# Pointer-Masking Control Register Bank

This block is the register bank behind a pointer-masking feature in a RISC-V-style core. It stores one shared control word and a mask/base register pair for each of the machine, supervisor and user levels. The control word can be reached through three address views: a machine view, a supervisor view and a user view. Each view exposes a different subset of the word's bits. Writes through a narrower view change only the bits that view can see.

The CSR stage drives an access strobe, a write flag, a 12-bit CSR address, write data and the current privilege. The bank returns combinational read data and an illegal-instruction flag. Writes commit on the clock edge.

Each accepted write marks the pointer-masking state dirty. In the same cycle the bank drives a set-mask toward the main status register. That mask raises the two extension-state bits and the summary-dirty bit. A lower level can lock its own registers against itself by clearing its "current" bit in the control word. The whole bank reports illegal accesses while the feature is switched off.

Top module: `ptrmask_csr_bank`

## Requirements
- R1: After reset, the control word reads 0x201: the state field in bits [1:0] is 1 (initial), machine current (bit 9) is 1 and all other bits are 0. All six mask and base registers read 0.
- R2: The addresses 0x3C0, 0x3C1 and 0x3C2 select the machine control view, mask and base. 0x1C0, 0x1C1 and 0x1C2 select the supervisor ones. 0x4C0, 0x4C1 and 0x4C2 select the user ones. Each mask and base register stores and returns the full XLEN-bit value written.
- R3: The control word groups its bits as follows:
  - bits [1:0]: state field.
  - bits 2/3/4: user enable/current/instruction.
  - bits 5/6/7: supervisor enable/current/instruction.
  - bits 8/9/10: machine enable/current/instruction.
  
  The machine view reads bits [10:0]. The supervisor view reads bits [7:0]. The user view reads bits [4:2]. Every other read bit is 0.
- R4: A write through the supervisor view (bits [7:0]) or the user view (bits [4:2]) changes only those bits. All other bits of the shared word keep their value.
- R5: Whatever data is written, bit 9 always stays 1 and bits 4, 7 and 10 always stay 0.
- R6: Every accepted write to any of the nine registers leaves the state field at 3 (dirty), whatever value was written into bits [1:0].
- R7: In the cycle of an accepted write, `status_set` has bits 16:15 and bit SD_POS (63 by default) high. At all other times `status_set` is 0.
- R8: Privilege is encoded U=0, S=1, M=3. A supervisor or user register's level is address bits [9:8]. If that level equals `cur_priv` and the level's current bit is 0, the write is dropped: nothing changes, no exception is raised and `status_set` stays 0. A write from a different level is accepted.
- R9: Writes to the machine view, machine mask and machine base are accepted at any privilege.
- R10: While `pm_enable` is 0, any access to the nine addresses raises `csr_illegal` and returns read data 0. No register changes and `status_set` stays 0. Other addresses never raise `csr_illegal`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pm_enable | input | 1 | Pointer-masking feature present and enabled |
| csr_valid | input | 1 | A CSR access is in progress this cycle |
| csr_we | input | 1 | The access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | Write data |
| cur_priv | input | 2 | Current privilege (U=0, S=1, M=3) |
| csr_rdata | output | XLEN | Read data of the addressed register or view |
| csr_illegal | output | 1 | Illegal-instruction indication |
| status_set | output | XLEN | Bits to set in the main status register |

## Verification
The bench targets the view masks with all-ones writes. A design that forgets to merge the hidden bits would let a supervisor write clear the machine group, or would let the machine enable be set through the supervisor view. It repeats writes with the state field zero and all ones. A missing hardwire or dirty-forcing step would then show a machine current bit of 0 or a stale state field. For the same-level gate, the bench compares a level writing its own registers with its current bit clear against the same write from a different level. A gate keyed on the wrong address bits or the wrong current bit would either drop legal writes or let locked ones through, and a dirty mark from a dropped write shows up as state 3 after reset. With the feature off, the bench watches for `csr_illegal`, for registers changing underneath it, and for `csr_illegal` on unrelated addresses.

// File: rtl/ptrmask_pkg.sv
package ptrmask_pkg;

  localparam int CW = 11;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int GRP_U = 2;
  localparam int GRP_S = 5;
  localparam int GRP_M = 8;
  localparam int OFS_EN  = 0;
  localparam int OFS_CUR = 1;
  localparam int OFS_INS = 2;

  localparam logic [1:0] ST_INITIAL = 2'd1;
  localparam logic [1:0] ST_DIRTY   = 2'd3;

  localparam logic [CW-1:0] CTRL_RESET =
    CW'(1) << (GRP_M + OFS_CUR) | CW'(ST_INITIAL);

  typedef enum logic [1:0] {
    KIND_CTRL = 2'd0,
    KIND_MASK = 2'd1,
    KIND_BASE = 2'd2,
    KIND_NONE = 2'd3
  } regkind_e;

  // bits visible through the view of a level
  function automatic logic [CW-1:0] view_mask(input logic [1:0] lvl);
    logic [CW-1:0] m;
    case (lvl)
      PRIV_M:  m = '1;
      PRIV_S:  m = CW'(8'hFF);
      PRIV_U:  m = CW'(3'b111) << GRP_U;
      default: m = '0;
    endcase
    return m;
  endfunction

  // current bit of a level as a one-hot word
  function automatic logic [CW-1:0] cur_bit_of(input logic [1:0] lvl);
    logic [CW-1:0] b;
    case (lvl)
      PRIV_M:  b = CW'(1) << (GRP_M + OFS_CUR);
      PRIV_S:  b = CW'(1) << (GRP_S + OFS_CUR);
      PRIV_U:  b = CW'(1) << (GRP_U + OFS_CUR);
      default: b = '0;
    endcase
    return b;
  endfunction

  function automatic logic [CW-1:0] merge_view(input logic [CW-1:0] old_w,
                                               input logic [CW-1:0] new_w,
                                               input logic [CW-1:0] vis);
    return (new_w & vis) | (old_w & ~vis);
  endfunction

  // hardwired bits and forced dirty state
  function automatic logic [CW-1:0] fixup(input logic [CW-1:0] w);
    logic [CW-1:0] r;
    r = w;
    r[GRP_M + OFS_CUR] = 1'b1;
    r[GRP_U + OFS_INS] = 1'b0;
    r[GRP_S + OFS_INS] = 1'b0;
    r[GRP_M + OFS_INS] = 1'b0;
    r[1:0] = ST_DIRTY;
    return r;
  endfunction

  function automatic logic [1:0] lvl_idx(input logic [1:0] lvl);
    logic [1:0] i;
    case (lvl)
      PRIV_S:  i = 2'd1;
      PRIV_M:  i = 2'd2;
      default: i = 2'd0;
    endcase
    return i;
  endfunction

endpackage

// File: rtl/ptrmask_decode.sv
module ptrmask_decode
  import ptrmask_pkg::*;
#(
  parameter logic [7:0] PAGE_LOW = 8'hC0
) (
  input  logic [11:0] addr,
  output logic        hit,
  output regkind_e    kind,
  output logic [1:0]  lvl
);
  logic page_ok;
  logic top_ok;

  always_comb begin
    page_ok = (addr[7:2] == PAGE_LOW[7:2]) && (addr[1:0] != 2'd3);
    top_ok  = (addr[11:8] == 4'h3) || (addr[11:8] == 4'h1) ||
              (addr[11:8] == 4'h4);
    hit     = page_ok && top_ok;
    lvl     = addr[9:8];
    case (addr[1:0])
      2'd0:    kind = KIND_CTRL;
      2'd1:    kind = KIND_MASK;
      2'd2:    kind = KIND_BASE;
      default: kind = KIND_NONE;
    endcase
    if (!hit) kind = KIND_NONE;
  end
endmodule

// File: rtl/ptrmask_ctrl.sv
module ptrmask_ctrl
  import ptrmask_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          view_wr,
  input  logic [1:0]    view_lvl,
  input  logic [CW-1:0] wdata,
  input  logic          mark_dirty,
  output logic [CW-1:0] ctrl_q
);
  logic [CW-1:0] view_next;

  always_comb view_next = fixup(merge_view(ctrl_q, wdata, view_mask(view_lvl)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ctrl_q <= CTRL_RESET;
    else if (view_wr)    ctrl_q <= view_next;
    else if (mark_dirty) ctrl_q[1:0] <= ST_DIRTY;
  end

  // R5
  hw_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[GRP_M+OFS_CUR] && !ctrl_q[GRP_U+OFS_INS] &&
    !ctrl_q[GRP_S+OFS_INS] && !ctrl_q[GRP_M+OFS_INS]);

  // R6
  dirty_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (view_wr || mark_dirty) |=> ctrl_q[1:0] == ST_DIRTY);
endmodule

// File: rtl/ptrmask_levelregs.sv
module ptrmask_levelregs #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_mask,
  input  logic            wr_base,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] mask_q,
  output logic [XLEN-1:0] base_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      base_q <= '0;
    end else begin
      if (wr_mask) mask_q <= wdata;
      if (wr_base) base_q <= wdata;
    end
  end
endmodule

// File: rtl/ptrmask_csr_bank.sv
module ptrmask_csr_bank
  import ptrmask_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int XS_LSB = 15,
  parameter int SD_POS = XLEN - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pm_enable,
  input  logic            csr_valid,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic [1:0]      cur_priv,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_illegal,
  output logic [XLEN-1:0] status_set
);
  localparam int NLVL = 3;
  localparam logic [XLEN-1:0] STATUS_BITS =
    (XLEN'(1) << SD_POS) | (XLEN'(3) << XS_LSB);

  logic          dec_hit;
  regkind_e      dec_kind;
  logic [1:0]    dec_lvl;
  logic [CW-1:0] ctrl_q;
  logic [XLEN-1:0] mask_q [NLVL];
  logic [XLEN-1:0] base_q [NLVL];

  logic access_hit, legal_wr, same_lvl, cur_ok, wr_blocked, wr_accept;
  logic ctrl_wr, pair_wr;
  logic [NLVL-1:0] wr_mask, wr_base;
  logic [1:0] sel_idx;

  ptrmask_decode u_decode (
    .addr (csr_addr),
    .hit  (dec_hit),
    .kind (dec_kind),
    .lvl  (dec_lvl)
  );

  always_comb begin
    access_hit  = csr_valid && dec_hit;
    csr_illegal = access_hit && !pm_enable;
    legal_wr    = access_hit && pm_enable && csr_we;
    same_lvl    = (cur_priv == dec_lvl);
    cur_ok      = |(ctrl_q & cur_bit_of(dec_lvl));
    wr_blocked  = legal_wr && (dec_lvl != PRIV_M) && same_lvl && !cur_ok;
    wr_accept   = legal_wr && !wr_blocked;
    ctrl_wr     = wr_accept && (dec_kind == KIND_CTRL);
    pair_wr     = wr_accept && (dec_kind != KIND_CTRL);
    sel_idx     = lvl_idx(dec_lvl);
    for (int g = 0; g < NLVL; g++) begin
      wr_mask[g] = wr_accept && (dec_kind == KIND_MASK) && (sel_idx == 2'(g));
      wr_base[g] = wr_accept && (dec_kind == KIND_BASE) && (sel_idx == 2'(g));
    end
    status_set  = wr_accept ? STATUS_BITS : '0;
  end

  ptrmask_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .view_wr    (ctrl_wr),
    .view_lvl   (dec_lvl),
    .wdata      (csr_wdata[CW-1:0]),
    .mark_dirty (pair_wr),
    .ctrl_q     (ctrl_q)
  );

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    ptrmask_levelregs #(.XLEN(XLEN)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_mask (wr_mask[g]),
      .wr_base (wr_base[g]),
      .wdata   (csr_wdata),
      .mask_q  (mask_q[g]),
      .base_q  (base_q[g])
    );
  end

  always_comb begin
    csr_rdata = '0;
    if (access_hit && pm_enable) begin
      for (int g = 0; g < NLVL; g++) begin
        if (sel_idx == 2'(g)) begin
          case (dec_kind)
            KIND_CTRL: csr_rdata = XLEN'(ctrl_q & view_mask(dec_lvl));
            KIND_MASK: csr_rdata = mask_q[g];
            KIND_BASE: csr_rdata = base_q[g];
            default:   csr_rdata = '0;
          endcase
        end
      end
    end
  end

  // R8
  drop_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> $stable(ctrl_q));

  // R10
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |=> $stable(ctrl_q));

  // R10
  illegal_nostatus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> (status_set == '0) && (csr_rdata == '0));

  // R3
  uview_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access_hit && pm_enable && dec_kind == KIND_CTRL && dec_lvl == PRIV_U)
      |-> (csr_rdata & ~XLEN'(32'h1C)) == '0);
endmodule

// File: tb/test_ptrmask_csr_bank.sv
`timescale 1ns/1ps
module test_ptrmask_csr_bank;
  localparam int XLEN = 64;
  localparam logic [63:0] STAT = 64'h8000_0000_0001_8000;

  logic clk = 0, rst_n = 0, pm_enable = 1, csr_valid = 0, csr_we = 0;
  logic [11:0] csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic [1:0]  cur_priv = 2'd3;
  logic [63:0] csr_rdata, status_set;
  logic        csr_illegal;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  ptrmask_csr_bank #(.XLEN(XLEN)) i_ptrmask_csr_bank (
    .clk, .rst_n, .pm_enable, .csr_valid, .csr_we, .csr_addr,
    .csr_wdata, .cur_priv, .csr_rdata, .csr_illegal, .status_set);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; csr_valid = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  // write; returns status_set and illegal seen in the write cycle
  task automatic wr(input logic [1:0] p, input logic [11:0] a, input logic [63:0] d,
                    output logic [63:0] st, output logic ill);
    @(negedge clk);
    cur_priv = p; csr_addr = a; csr_wdata = d; csr_we = 1; csr_valid = 1;
    #2 st = status_set; ill = csr_illegal;
    @(posedge clk); #1 csr_valid = 0; csr_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] v, output logic ill);
    @(negedge clk);
    csr_addr = a; csr_we = 0; csr_valid = 1;
    #2 v = csr_rdata; ill = csr_illegal;
    @(negedge clk); csr_valid = 0;
  endtask

  task automatic t_reset();
    logic [63:0] v; logic ill;
    do_reset();
    rd(12'h3C0, v, ill); check("R1 mctrl reset", v, 64'h201);
    rd(12'h1C0, v, ill); check("R1 sview reset", v, 64'h001);
    rd(12'h4C0, v, ill); check("R1 uview reset", v, 64'h0);
    rd(12'h1C1, v, ill); check("R1 smask reset", v, 64'h0);
    rd(12'h4C2, v, ill); check("R1 ubase reset", v, 64'h0);
    check("R7 status idle", status_set, 64'h0);
  endtask

  task automatic t_mregs();
    logic [63:0] v, st; logic ill;
    wr(2'd3, 12'h3C1, 64'hDEAD_BEEF_0123_4567, st, ill);
    check("R7 status on write", st, STAT);
    rd(12'h3C1, v, ill); check("R2 mmask", v, 64'hDEAD_BEEF_0123_4567);
    wr(2'd3, 12'h3C2, 64'hF0F0_0000_1111_2222, st, ill);
    rd(12'h3C2, v, ill); check("R2 mbase", v, 64'hF0F0_0000_1111_2222);
    rd(12'h3C1, v, ill); check("R2 mmask kept", v, 64'hDEAD_BEEF_0123_4567);
    rd(12'h3C0, v, ill); check("R6 dirty by mask write", v, 64'h203);
  endtask

  task automatic t_hardwire();
    logic [63:0] v, st; logic ill;
    wr(2'd3, 12'h3C0, '1, st, ill);
    rd(12'h3C0, v, ill); check("R5 all ones mview", v, 64'h36F);
    rd(12'h1C0, v, ill); check("R3 sview", v, 64'h6F);
    rd(12'h4C0, v, ill); check("R3 uview", v, 64'h0C);
    wr(2'd3, 12'h3C0, 64'h0, st, ill);
    rd(12'h3C0, v, ill); check("R5 zero write keeps mcur", v, 64'h203);
    wr(2'd3, 12'h3C0, 64'h1, st, ill);
    rd(12'h3C0, v, ill); check("R6 state forced dirty", v, 64'h203);
  endtask

  task automatic t_views();
    logic [63:0] v, st; logic ill;
    wr(2'd3, 12'h1C0, '1, st, ill);
    rd(12'h3C0, v, ill); check("R4 sview ones merged", v, 64'h26F);
    wr(2'd3, 12'h4C0, 64'h0, st, ill);
    rd(12'h3C0, v, ill); check("R4 uview zero merged", v, 64'h263);
    wr(2'd3, 12'h3C0, 64'h0, st, ill);
    wr(2'd3, 12'h1C0, 64'h700, st, ill);
    rd(12'h3C0, v, ill); check("R4 sview hides m bits", v, 64'h203);
  endtask

  task automatic t_gate();
    logic [63:0] v, st; logic ill;
    do_reset();
    wr(2'd1, 12'h1C1, 64'h55, st, ill);
    check("R8 dropped no status", st, 64'h0);
    check("R8 dropped no illegal", {63'b0, ill}, 64'h0);
    rd(12'h1C1, v, ill); check("R8 smask unchanged", v, 64'h0);
    rd(12'h3C0, v, ill); check("R8 dropped not dirty", v, 64'h201);
    wr(2'd0, 12'h4C2, 64'h66, st, ill);
    rd(12'h4C2, v, ill); check("R8 ubase dropped", v, 64'h0);
    wr(2'd1, 12'h4C1, 64'h77, st, ill);
    check("R8 cross-level status", st, STAT);
    rd(12'h4C1, v, ill); check("R8 cross-level write", v, 64'h77);
    wr(2'd0, 12'h4C0, 64'h1C, st, ill);
    rd(12'h3C0, v, ill); check("R8 uview dropped", v, 64'h203);
    wr(2'd3, 12'h3C0, 64'h48, st, ill);
    rd(12'h3C0, v, ill); check("R8 set current bits", v, 64'h24B);
    wr(2'd1, 12'h1C2, 64'h99, st, ill);
    rd(12'h1C2, v, ill); check("R8 sbase own level allowed", v, 64'h99);
    wr(2'd0, 12'h4C0, 64'h04, st, ill);
    rd(12'h3C0, v, ill); check("R8 uview own level allowed", v, 64'h247);
    wr(2'd0, 12'h4C0, 64'h1C, st, ill);
    check("R8 relocked no status", st, 64'h0);
    rd(12'h3C0, v, ill); check("R8 relocked dropped", v, 64'h247);
  endtask

  task automatic t_mungated();
    logic [63:0] v, st; logic ill;
    wr(2'd3, 12'h3C2, 64'h1357, st, ill);
    check("R9 mbase status", st, STAT);
    rd(12'h3C2, v, ill); check("R9 mbase written", v, 64'h1357);
    wr(2'd3, 12'h1C0, 64'h0, st, ill);
    rd(12'h3C0, v, ill); check("R9 sview from M", v, 64'h203);
  endtask

  task automatic t_disabled();
    logic [63:0] v, st; logic ill;
    pm_enable = 0;
    wr(2'd3, 12'h3C2, 64'h1234, st, ill);
    check("R10 write illegal", {63'b0, ill}, 64'h1);
    check("R10 write no status", st, 64'h0);
    rd(12'h4C0, v, ill);
    check("R10 read illegal", {63'b0, ill}, 64'h1);
    check("R10 read zero", v, 64'h0);
    rd(12'h300, v, ill);
    check("R10 other addr legal", {63'b0, ill}, 64'h0);
    pm_enable = 1;
    rd(12'h3C2, v, ill); check("R10 mbase unchanged", v, 64'h1357);
    rd(12'h3C0, v, ill); check("R10 ctrl unchanged", v, 64'h203);
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_mregs();
    t_hardwire();
    t_views();
    t_gate();
    t_mungated();
    t_disabled();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule